// File: doc/BRIEF.md
# Oscillator Register Programming Sequencer

This block configures a digitally controlled oscillator over a two-wire serial bus. It sits above a byte-level bus master. That master takes single commands (bus check, start condition, stop condition, byte write, byte read) and answers each one with a completion pulse, an acknowledge flag and a read byte. The sequencer turns three high-level requests into register transactions aimed at the device at 7-bit address 0x67.

The programming request runs a fixed bring-up:
- a bus check;
- a page select;
- a soft reset, whose data byte the device does not acknowledge;
- a long settling pause;
- housekeeping writes;
- a presence test that writes and reads back every value from 0 up to a limit, because the part has no identification register;
- the divider writes;
- the calibration start;
- the output enable.

The trim request writes a signed 24-bit frequency-trim word and then pauses briefly. The readback request reads the trim word back and presents it sign-extended. Any failure stops the sequence and leaves an error code that holds until the next request.

Top module: `osc_prog_seq`

## Requirements
- R1: A register write issues, in order, START, WR(address<<1 | 0), WR(register index), WR(value) and STOP. The command codes are INIT=0, START=1, STOP=2, WR=3 and RD=4. WR carries its byte on `bus_wdata`. A command is held stable until `bus_cmd_done`.
- R2: A register read issues START, WR(address<<1), WR(index), STOP, START, WR(address<<1 | 1), RD and STOP. The RD command never acknowledges its byte.
- R3: A missing acknowledge aborts the transaction and sets an error code: 2 for the address byte, 3 for the register byte, 4 for the value byte and 6 for the read-address byte. A STOP is then issued, `done` pulses and no further command follows.
- R4: Programming runs INIT, then writes 0x00 to 255 and 0x80 to 7, with no acknowledge check on that value byte. It then waits at least `RST_WAIT_CYC` cycles with the bus quiet. After that it writes 0x00 to 255, 69 and 17, in that order.
- R5: Presence test: for k = 0 to `PRESENCE_LAST`, write k to register 23 and read register 23 back. Any mismatch ends the job with error code 5 and no further bus command.
- R6: After the presence test, the sequencer writes the high-speed divider bits 7:0 to register 23. Register 24 receives {0, low-speed divider, 0, high-speed divider bits 10:8}. Registers 26 to 31 receive the 48-bit feedback divider, low byte first. Then 0x08 goes to register 7, and finally 0x01 goes to register 17.
- R7: A trim request writes the trim word to registers 231, 232 and 233, low byte first. It then keeps the bus quiet for at least `TRIM_WAIT_CYC` cycles before `done`.
- R8: A readback request reads registers 231, 232 and 233 and places the bytes in bits 7:0, 15:8 and 23:16. `trim_rd` shows that word with bit 23 copied into all upper bits.
- R9: `busy` is high from the cycle after an accepted request until `done`. `done` is a one-cycle pulse with `busy` low. Requests that arrive while busy are ignored. `err_code` holds its value between jobs and returns to 0 when a new job is accepted. When requests arrive together, program wins over trim, and trim wins over readback.
- R10: An INIT that is not acknowledged ends programming with error code 1, after a STOP.
- R11: After reset, `busy`, `done`, `err_code`, `trim_rd` and `bus_cmd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_req | input | 1 | Start the full programming job |
| hs_div | input | 11 | High-speed output divider |
| ls_div | input | 3 | Low-speed output divider |
| fb_div | input | 48 | Feedback divider |
| trim_req | input | 1 | Start a trim write |
| trim_word | input | 24 | Signed frequency-trim word |
| rdbk_req | input | 1 | Start a trim readback |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err_code | output | 3 | Result of the last job (0 = success) |
| trim_rd | output | TRIM_OUT_W | Read-back trim word, sign-extended |
| bus_cmd_valid | output | 1 | Command presented to the byte master |
| bus_cmd | output | 3 | Command code |
| bus_wdata | output | 8 | Byte for WR |
| bus_cmd_done | input | 1 | Byte master finished the command |
| bus_ack | input | 1 | Acknowledge seen (for INIT: bus free) |
| bus_rdata | input | 8 | Byte returned by RD |

## Verification
The assertions assume the byte master obeys a handshake: it raises `bus_cmd_done` for exactly one cycle, only while a command is presented, and keeps `bus_ack` and `bus_rdata` valid in that cycle. The bench's responder follows this rule. It answers each command two cycles after it appears and drops the completion pulse at the next cycle. It also emulates a register-file device, which withholds the acknowledge on the reset data byte. Fault cases come from this model: a withheld acknowledge on a chosen write byte, a corrupted readback at one presence value, and a stuck bus check. The model never asserts completion without a pending command.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;

   localparam int HS_W       = 11;
   localparam int LS_W       = 3;
   localparam int FB_W       = 48;
   localparam int TRIM_W     = 24;
   localparam int FB_BYTES   = FB_W / 8;
   localparam int TRIM_BYTES = TRIM_W / 8;
   localparam int STEP_W     = 5;

   typedef enum logic [2:0] {
      BC_INIT  = 3'd0,
      BC_START = 3'd1,
      BC_STOP  = 3'd2,
      BC_WR    = 3'd3,
      BC_RD    = 3'd4
   } bus_cmd_e;

   typedef enum logic [2:0] {
      OP_INIT, OP_WR, OP_WR_NOVAL, OP_RD, OP_WAIT, OP_END
   } op_e;

   typedef enum logic [2:0] {
      ERR_NONE   = 3'd0,
      ERR_BUS    = 3'd1,
      ERR_ADDR   = 3'd2,
      ERR_REG    = 3'd3,
      ERR_VAL    = 3'd4,
      ERR_DETECT = 3'd5,
      ERR_RADDR  = 3'd6
   } err_e;

   typedef enum logic [1:0] {JOB_PROG, JOB_TRIM, JOB_RDBK} job_e;

   typedef struct packed {
      op_e        op;
      logic [7:0] reg_idx;
      logic [7:0] val;
      logic       long_wait;
   } step_t;

endpackage

// File: rtl/osc_wait_timer.sv
module osc_wait_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/osc_step_table.sv
module osc_step_table
   import osc_seq_pkg::*;
(
   input  job_e                     job,
   input  logic [STEP_W-1:0]        step,
   input  logic [7:0]               k,
   input  logic [HS_W-1:0]          hs,
   input  logic [LS_W-1:0]          ls,
   input  logic [FB_W-1:0]          fb,
   input  logic [TRIM_W-1:0]        trim,
   output step_t                    st
);

   logic [7:0] fb_b   [FB_BYTES];
   logic [7:0] trim_b [TRIM_BYTES];

   for (genvar gi = 0; gi < FB_BYTES; gi++) begin : g_fb
      assign fb_b[gi] = fb[8*gi +: 8];
   end
   for (genvar gj = 0; gj < TRIM_BYTES; gj++) begin : g_trim
      assign trim_b[gj] = trim[8*gj +: 8];
   end

   logic [STEP_W-1:0] fi;
   assign fi = step - STEP_W'(11);

   always_comb begin
      st = '{op: OP_END, reg_idx: 8'd0, val: 8'd0, long_wait: 1'b0};
      unique case (job)
         JOB_PROG: begin
            case (step)
               5'd0:  st.op = OP_INIT;
               5'd1:  begin st.op = OP_WR;       st.reg_idx = 8'd255; end
               5'd2:  begin st.op = OP_WR_NOVAL; st.reg_idx = 8'd7;  st.val = 8'h80; end
               5'd3:  begin st.op = OP_WAIT;     st.long_wait = 1'b1; end
               5'd4:  begin st.op = OP_WR;       st.reg_idx = 8'd255; end
               5'd5:  begin st.op = OP_WR;       st.reg_idx = 8'd69; end
               5'd6:  begin st.op = OP_WR;       st.reg_idx = 8'd17; end
               5'd7:  begin st.op = OP_WR;       st.reg_idx = 8'd23; st.val = k; end
               5'd8:  begin st.op = OP_RD;       st.reg_idx = 8'd23; end
               5'd9:  begin st.op = OP_WR;       st.reg_idx = 8'd23; st.val = hs[7:0]; end
               5'd10: begin
                  st.op = OP_WR; st.reg_idx = 8'd24;
                  st.val = {1'b0, ls, 1'b0, hs[HS_W-1:8]};
               end
               5'd11, 5'd12, 5'd13, 5'd14, 5'd15, 5'd16: begin
                  st.op = OP_WR;
                  st.reg_idx = 8'd26 + {5'd0, fi[2:0]};
                  st.val = fb_b[fi[2:0]];
               end
               5'd17: begin st.op = OP_WR; st.reg_idx = 8'd7;  st.val = 8'h08; end
               5'd18: begin st.op = OP_WR; st.reg_idx = 8'd17; st.val = 8'h01; end
               default: st.op = OP_END;
            endcase
         end
         JOB_TRIM: begin
            if (step < STEP_W'(TRIM_BYTES)) begin
               st.op = OP_WR;
               st.reg_idx = 8'd231 + {6'd0, step[1:0]};
               st.val = trim_b[step[1:0]];
            end else if (step == STEP_W'(TRIM_BYTES)) begin
               st.op = OP_WAIT;
            end
         end
         default: begin
            if (step < STEP_W'(TRIM_BYTES)) begin
               st.op = OP_RD;
               st.reg_idx = 8'd231 + {6'd0, step[1:0]};
            end
         end
      endcase
   end

endmodule

// File: rtl/osc_reg_xfer.sv
module osc_reg_xfer
   import osc_seq_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h67
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  op_e        op,
   input  logic [7:0] reg_idx,
   input  logic [7:0] wval,
   output logic       fin,
   output err_e       fin_err,
   output logic [7:0] rdata,
   output logic       bus_cmd_valid,
   output bus_cmd_e   bus_cmd,
   output logic [7:0] bus_wdata,
   input  logic       bus_cmd_done,
   input  logic       bus_ack,
   input  logic [7:0] bus_rdata
);

   typedef enum logic [1:0] {X_IDLE, X_RUN, X_ABORT, X_FIN} xst_e;

   xst_e       state_q;
   op_e        op_q;
   logic [7:0] reg_q, val_q, rd_q;
   logic [2:0] ph_q;
   err_e       err_q;

   bus_cmd_e   cmd_c;
   logic [7:0] wd_c;
   logic       last_c;
   err_e       chk_c;
   logic       fail_now;

   always_comb begin
      cmd_c  = BC_STOP;
      wd_c   = 8'h00;
      last_c = 1'b0;
      chk_c  = ERR_NONE;
      case (op_q)
         OP_INIT: begin cmd_c = BC_INIT; last_c = 1'b1; chk_c = ERR_BUS; end
         OP_WR, OP_WR_NOVAL: begin
            case (ph_q)
               3'd0: cmd_c = BC_START;
               3'd1: begin cmd_c = BC_WR; wd_c = {DEV_ADDR, 1'b0}; chk_c = ERR_ADDR; end
               3'd2: begin cmd_c = BC_WR; wd_c = reg_q; chk_c = ERR_REG; end
               3'd3: begin
                  cmd_c = BC_WR; wd_c = val_q;
                  chk_c = (op_q == OP_WR) ? ERR_VAL : ERR_NONE;
               end
               default: last_c = 1'b1;
            endcase
         end
         OP_RD: begin
            case (ph_q)
               3'd0: cmd_c = BC_START;
               3'd1: begin cmd_c = BC_WR; wd_c = {DEV_ADDR, 1'b0}; chk_c = ERR_ADDR; end
               3'd2: begin cmd_c = BC_WR; wd_c = reg_q; chk_c = ERR_REG; end
               3'd3: cmd_c = BC_STOP;
               3'd4: cmd_c = BC_START;
               3'd5: begin cmd_c = BC_WR; wd_c = {DEV_ADDR, 1'b1}; chk_c = ERR_RADDR; end
               3'd6: cmd_c = BC_RD;
               default: last_c = 1'b1;
            endcase
         end
         default: last_c = 1'b1;
      endcase
   end

   assign fail_now = (chk_c != ERR_NONE) && !bus_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= X_IDLE;
         op_q    <= OP_END;
         reg_q   <= '0;
         val_q   <= '0;
         rd_q    <= '0;
         ph_q    <= '0;
         err_q   <= ERR_NONE;
      end else begin
         unique case (state_q)
            X_IDLE: if (start) begin
               op_q    <= op;
               reg_q   <= reg_idx;
               val_q   <= wval;
               ph_q    <= '0;
               err_q   <= ERR_NONE;
               state_q <= X_RUN;
            end
            X_RUN: if (bus_cmd_done) begin
               if (fail_now) begin
                  err_q   <= chk_c;
                  state_q <= X_ABORT;
               end else begin
                  if (op_q == OP_RD && ph_q == 3'd6) rd_q <= bus_rdata;
                  if (last_c) state_q <= X_FIN;
                  else        ph_q    <= ph_q + 1'b1;
               end
            end
            X_ABORT: if (bus_cmd_done) state_q <= X_FIN;
            default: state_q <= X_IDLE;
         endcase
      end
   end

   assign bus_cmd_valid = (state_q == X_RUN) || (state_q == X_ABORT);
   assign bus_cmd       = (state_q == X_RUN) ? cmd_c : BC_STOP;
   assign bus_wdata     = (state_q == X_RUN) ? wd_c  : 8'h00;
   assign fin           = (state_q == X_FIN);
   assign fin_err       = err_q;
   assign rdata         = rd_q;

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cmd_valid && !bus_cmd_done |=> bus_cmd_valid && $stable(bus_cmd) && $stable(bus_wdata)); // R1

   AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == X_RUN) && bus_cmd_done && fail_now |=> bus_cmd_valid && bus_cmd == BC_STOP); // R3

endmodule

// File: rtl/osc_prog_seq.sv
module osc_prog_seq
   import osc_seq_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR      = 7'h67,
   parameter int unsigned RST_WAIT_CYC  = 12_500_000,
   parameter int unsigned TRIM_WAIT_CYC = 12_500,
   parameter int unsigned PRESENCE_LAST = 254,
   parameter int          TRIM_OUT_W    = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  prog_req,
   input  logic [10:0]           hs_div,
   input  logic [2:0]            ls_div,
   input  logic [47:0]           fb_div,
   input  logic                  trim_req,
   input  logic [23:0]           trim_word,
   input  logic                  rdbk_req,
   output logic                  busy,
   output logic                  done,
   output logic [2:0]            err_code,
   output logic [TRIM_OUT_W-1:0] trim_rd,
   output logic                  bus_cmd_valid,
   output logic [2:0]            bus_cmd,
   output logic [7:0]            bus_wdata,
   input  logic                  bus_cmd_done,
   input  logic                  bus_ack,
   input  logic [7:0]            bus_rdata
);

   localparam int unsigned WAIT_MAX = (RST_WAIT_CYC > TRIM_WAIT_CYC) ? RST_WAIT_CYC : TRIM_WAIT_CYC;
   localparam int          CNT_W    = $clog2(WAIT_MAX + 1);

   if (PRESENCE_LAST > 254) begin : g_bad_presence
      $error("PRESENCE_LAST must fit a register value below 255");
   end
   if (RST_WAIT_CYC < 1 || TRIM_WAIT_CYC < 1) begin : g_bad_wait
      $error("wait lengths must be at least one cycle");
   end
   if (TRIM_OUT_W < TRIM_W) begin : g_bad_trim_w
      $error("TRIM_OUT_W must hold the 24-bit trim word");
   end

   typedef enum logic [2:0] {T_IDLE, T_DISPATCH, T_XFER, T_WAIT, T_DONE} tst_e;

   tst_e              state_q;
   job_e              job_q;
   logic [STEP_W-1:0] step_q;
   logic [7:0]        k_q;
   err_e              err_q;
   logic [HS_W-1:0]   hs_q;
   logic [LS_W-1:0]   ls_q;
   logic [FB_W-1:0]   fb_q;
   logic [TRIM_W-1:0] trim_q;
   logic [TRIM_W-1:0] rb_q;

   step_t      st;
   logic       x_start, x_fin;
   err_e       x_err;
   logic [7:0] x_rdata;
   bus_cmd_e   x_cmd;
   logic       t_load, t_exp;

   osc_step_table u_table (
      .job  (job_q),
      .step (step_q),
      .k    (k_q),
      .hs   (hs_q),
      .ls   (ls_q),
      .fb   (fb_q),
      .trim (trim_q),
      .st   (st)
   );

   assign x_start = (state_q == T_DISPATCH) &&
                    (st.op != OP_END) && (st.op != OP_WAIT);
   assign t_load  = (state_q == T_DISPATCH) && (st.op == OP_WAIT);

   osc_reg_xfer #(.DEV_ADDR(DEV_ADDR)) u_xfer (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (x_start),
      .op            (st.op),
      .reg_idx       (st.reg_idx),
      .wval          (st.val),
      .fin           (x_fin),
      .fin_err       (x_err),
      .rdata         (x_rdata),
      .bus_cmd_valid (bus_cmd_valid),
      .bus_cmd       (x_cmd),
      .bus_wdata     (bus_wdata),
      .bus_cmd_done  (bus_cmd_done),
      .bus_ack       (bus_ack),
      .bus_rdata     (bus_rdata)
   );

   osc_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (st.long_wait ? CNT_W'(RST_WAIT_CYC) : CNT_W'(TRIM_WAIT_CYC)),
      .expired  (t_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= T_IDLE;
         job_q   <= JOB_PROG;
         step_q  <= '0;
         k_q     <= '0;
         err_q   <= ERR_NONE;
         hs_q    <= '0;
         ls_q    <= '0;
         fb_q    <= '0;
         trim_q  <= '0;
         rb_q    <= '0;
      end else begin
         unique case (state_q)
            T_IDLE: begin
               if (prog_req || trim_req || rdbk_req) begin
                  step_q  <= '0;
                  k_q     <= '0;
                  err_q   <= ERR_NONE;
                  state_q <= T_DISPATCH;
                  if (prog_req) begin
                     job_q <= JOB_PROG;
                     hs_q  <= hs_div;
                     ls_q  <= ls_div;
                     fb_q  <= fb_div;
                  end else if (trim_req) begin
                     job_q  <= JOB_TRIM;
                     trim_q <= trim_word;
                  end else begin
                     job_q <= JOB_RDBK;
                  end
               end
            end
            T_DISPATCH: begin
               if (st.op == OP_END)       state_q <= T_DONE;
               else if (st.op == OP_WAIT) state_q <= T_WAIT;
               else                       state_q <= T_XFER;
            end
            T_XFER: if (x_fin) begin
               if (x_err != ERR_NONE) begin
                  err_q   <= x_err;
                  state_q <= T_DONE;
               end else if (st.op == OP_RD && job_q == JOB_PROG) begin
                  if (x_rdata != k_q) begin
                     err_q   <= ERR_DETECT;
                     state_q <= T_DONE;
                  end else if (k_q == PRESENCE_LAST[7:0]) begin
                     step_q  <= step_q + 1'b1;
                     state_q <= T_DISPATCH;
                  end else begin
                     k_q     <= k_q + 1'b1;
                     step_q  <= step_q - 1'b1;
                     state_q <= T_DISPATCH;
                  end
               end else begin
                  if (st.op == OP_RD) begin
                     case (step_q[1:0])
                        2'd0:    rb_q[7:0]   <= x_rdata;
                        2'd1:    rb_q[15:8]  <= x_rdata;
                        default: rb_q[23:16] <= x_rdata;
                     endcase
                  end
                  step_q  <= step_q + 1'b1;
                  state_q <= T_DISPATCH;
               end
            end
            T_WAIT: if (t_exp) begin
               step_q  <= step_q + 1'b1;
               state_q <= T_DISPATCH;
            end
            default: state_q <= T_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != T_IDLE) && (state_q != T_DONE);
   assign done     = (state_q == T_DONE);
   assign err_code = err_q;
   assign bus_cmd  = x_cmd;

   if (TRIM_OUT_W > TRIM_W) begin : g_sext
      assign trim_rd = {{(TRIM_OUT_W-TRIM_W){rb_q[TRIM_W-1]}}, rb_q};
   end else begin : g_plain
      assign trim_rd = rb_q;
   end

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !bus_cmd_valid); // R9

   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !done && !(prog_req || trim_req || rdbk_req) |=> $stable(err_code)); // R9

   AST_ERR_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_code) |-> busy || done); // R9

   AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == T_WAIT |-> !bus_cmd_valid); // R7

endmodule

// File: tb/osc_prog_seq_bench.sv
module osc_prog_seq_bench;

   localparam int RSTW = 40;
   localparam int TRW  = 25;
   localparam int PL   = 254;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        prog_req = 0, trim_req = 0, rdbk_req = 0;
   logic [10:0] hs_div = '0;
   logic [2:0]  ls_div = '0;
   logic [47:0] fb_div = '0;
   logic [23:0] trim_word = '0;
   logic        busy, done, bus_cmd_valid;
   logic [2:0]  err_code, bus_cmd;
   logic [31:0] trim_rd;
   logic [7:0]  bus_wdata;
   logic        bus_cmd_done = 0, bus_ack = 0;
   logic [7:0]  bus_rdata = '0;

   always #2 clk = ~clk;

   osc_prog_seq #(.RST_WAIT_CYC(RSTW), .TRIM_WAIT_CYC(TRW), .PRESENCE_LAST(PL)) u_osc_prog_seq (
      .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .hs_div(hs_div), .ls_div(ls_div),
      .fb_div(fb_div), .trim_req(trim_req), .trim_word(trim_word), .rdbk_req(rdbk_req),
      .busy(busy), .done(done), .err_code(err_code), .trim_rd(trim_rd),
      .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_wdata(bus_wdata),
      .bus_cmd_done(bus_cmd_done), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   int n_checks = 0, n_errors = 0;
   int cyc = 0, done_cnt = 0, done_cyc = 0;
   int log_q[$], exp_q[$], resp_cyc[$];
   logic [7:0] mem [256];
   int phase = 0, wr_cnt = 0, nack_at = 0, corrupt_val = -1, lat = 0;
   bit init_stuck = 0;
   logic [7:0] ptr = 0;

   task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
      end
   endtask

   // byte-level master plus device register file
   task automatic respond();
      bit a = 1;
      bus_rdata = 8'h00;
      case (bus_cmd)
         3'd0: a = !init_stuck;
         3'd1: phase = 0;
         3'd3: begin
            wr_cnt++;
            if (wr_cnt == nack_at) a = 0;
            else if (phase == 0) begin a = (bus_wdata[7:1] == 7'h67); phase = 1; end
            else if (phase == 1) begin ptr = bus_wdata; phase = 2; end
            else begin
               mem[ptr] = bus_wdata;
               if (ptr == 8'd7 && bus_wdata == 8'h80) a = 0;
            end
         end
         3'd4: begin
            bus_rdata = mem[ptr];
            if (ptr == 8'd23 && int'(mem[ptr]) == corrupt_val) bus_rdata = mem[ptr] ^ 8'h01;
         end
         default: ;
      endcase
      bus_ack = a;
      log_q.push_back(int'(bus_cmd) * 256 + ((bus_cmd == 3'd3) ? int'(bus_wdata) : 0));
      resp_cyc.push_back(cyc);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (bus_cmd_done) bus_cmd_done = 0;
         else if (bus_cmd_valid && rst_n) begin
            lat++;
            if (lat >= 2) begin lat = 0; respond(); bus_cmd_done = 1; end
         end
      end
   end

   // per-clock comparison against the handshake model
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            chk(!(bus_cmd_valid && !busy), "R9", "command while idle", bus_cmd_valid, 0);
            chk(!(done && busy), "R9", "done with busy", busy, 0);
            if (done) done_cnt++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   task automatic e(input int c, input int d); exp_q.push_back(c * 256 + d); endtask
   task automatic ew(input int r, input int v);
      e(1,0); e(3,8'hCE); e(3,r); e(3,v); e(2,0);
   endtask
   task automatic er(input int r);
      e(1,0); e(3,8'hCE); e(3,r); e(2,0); e(1,0); e(3,8'hCF); e(4,0); e(2,0);
   endtask
   task automatic e_prefix();
      e(0,0); ew(255,0); ew(7,8'h80); ew(255,0); ew(69,0); ew(17,0);
   endtask

   task automatic run_job(input int which);
      log_q.delete(); resp_cyc.delete(); wr_cnt = 0;
      @(negedge clk);
      case (which)
         0: prog_req = 1;
         1: trim_req = 1;
         default: rdbk_req = 1;
      endcase
      @(negedge clk);
      prog_req = 0; trim_req = 0; rdbk_req = 0;
      while (!done) @(negedge clk);
      done_cyc = cyc;
   endtask

   task automatic cmp_stream(input string rq);
      int n;
      chk(log_q.size() == exp_q.size(), rq, "stream length", log_q.size(), exp_q.size());
      n = (log_q.size() < exp_q.size()) ? log_q.size() : exp_q.size();
      for (int i = 0; i < n; i++)
         chk(log_q[i] == exp_q[i], rq, $sformatf("bus item %0d", i), log_q[i], exp_q[i]);
      exp_q.delete();
   endtask

   initial begin
      int gap, d0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !done && err_code == 0 && trim_rd == 0 && !bus_cmd_valid, "R11",
          "reset outputs", {busy, done, err_code, bus_cmd_valid}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // full programming run, with a trim request arriving mid-run (R9 ignored)
      hs_div = 11'h6A5; ls_div = 3'd5; fb_div = 48'h04B5_C447_2135; trim_word = 24'h00AAAA;
      fork
         run_job(0);
         begin repeat (300) @(negedge clk); trim_req = 1; @(negedge clk); trim_req = 0; end
      join
      chk(err_code == 0, "R6", "program error code", err_code, 0);
      e_prefix();
      for (int k = 0; k <= PL; k++) begin ew(23, k); er(23); end
      ew(23, 8'hA5); ew(24, 8'h56);
      ew(26,8'h35); ew(27,8'h21); ew(28,8'h47); ew(29,8'hC4); ew(30,8'hB5); ew(31,8'h04);
      ew(7, 8'h08); ew(17, 8'h01);
      gap = resp_cyc[11] - resp_cyc[10];
      chk(gap >= RSTW, "R4", "reset settle gap", gap, RSTW);
      cmp_stream("R4 R5 R6 R1 R2");
      chk(mem[24] == 8'h56 && mem[29] == 8'hC4 && mem[17] == 8'h01 && mem[7] == 8'h08,
          "R6", "device registers", {mem[24], mem[29]}, 16'h56C4);
      d0 = done_cnt;
      repeat (20) @(negedge clk);
      chk(done_cnt == d0 && !busy, "R9", "request while busy ignored", done_cnt, d0);

      // trim write, negative word
      trim_word = 24'h812345;
      run_job(1);
      ew(231, 8'h45); ew(232, 8'h23); ew(233, 8'h81);
      cmp_stream("R7 R1");
      gap = done_cyc - resp_cyc[resp_cyc.size()-1];
      chk(gap >= TRW && gap <= TRW + 8, "R7", "post-trim pause", gap, TRW);
      chk(err_code == 0, "R7", "trim error code", err_code, 0);

      // readback sign-extended
      run_job(2);
      er(231); er(232); er(233);
      cmp_stream("R2");
      chk(trim_rd == 32'hFF812345, "R8", "negative readback", trim_rd, 32'hFF812345);
      trim_word = 24'h012345;
      run_job(1);
      run_job(2);
      chk(trim_rd == 32'h00012345, "R8", "positive readback", trim_rd, 32'h00012345);
      exp_q.delete();

      // nack on address
      nack_at = 1; run_job(1);
      e(1,0); e(3,8'hCE); e(2,0); cmp_stream("R3");
      chk(err_code == 2, "R3", "address nack code", err_code, 2);
      repeat (5) @(negedge clk);
      chk(err_code == 2, "R9", "error held", err_code, 2);
      // nack on register
      nack_at = 2; run_job(1);
      e(1,0); e(3,8'hCE); e(3,231); e(2,0); cmp_stream("R3");
      chk(err_code == 3, "R3", "register nack code", err_code, 3);
      // nack on value
      nack_at = 3; run_job(1);
      e(1,0); e(3,8'hCE); e(3,231); e(3,8'h45); e(2,0); cmp_stream("R3");
      chk(err_code == 4, "R3", "value nack code", err_code, 4);
      // nack on read address
      nack_at = 3; run_job(2);
      e(1,0); e(3,8'hCE); e(3,231); e(2,0); e(1,0); e(3,8'hCF); e(2,0); cmp_stream("R3");
      chk(err_code == 6, "R3", "read address nack code", err_code, 6);
      nack_at = 0;
      run_job(1);
      chk(err_code == 0, "R9", "error cleared by new job", err_code, 0);

      // presence mismatch
      corrupt_val = 3; run_job(0);
      e_prefix();
      for (int k = 0; k <= 3; k++) begin ew(23, k); er(23); end
      cmp_stream("R5");
      chk(err_code == 5, "R5", "detection code", err_code, 5);
      corrupt_val = -1;

      // stuck bus at init
      init_stuck = 1; run_job(0);
      e(0,0); e(2,0); cmp_stream("R10");
      chk(err_code == 1, "R10", "bus check code", err_code, 1);
      init_stuck = 0;

      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule